// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block answers, in the same cycle as the fetch address is presented, three questions for the fetch unit: is there a known branch at this address, is it expected to be taken, and where will it go. Direction comes from a table of two-bit saturating counters indexed by the low address bits. The destination comes from a tagged target buffer. For return instructions the destination comes from a small hardware stack of return addresses.

All learning arrives through a resolve port that carries one retired branch per cycle: its address, its outcome, its real destination, and whether it was a call or a return. Calls push their fall-through address onto the return stack and returns pop it. A flush input empties the return stack so that stale return addresses are not used after the pipeline is redirected. The counter table has no tag, so two branches that share an index also share a counter.

Top module: `branch_predictor`

## Requirements
- R1: After reset no address hits, predict_taken is 0 and predicted_target is fetch_pc+4.
- R2: A buffer hit requires the stored tag, fetch_pc[31:8], to equal the lookup's. The entry is chosen by the index fetch_pc[7:2]. A different address with the same index does not hit, and a taken update from it replaces the entry.
- R3: Each counter resets to 1, counts up on a taken update and down on a not-taken one, saturates at 0 and 3, and predicts taken when it is 2 or 3.
- R4: A counter at 3 still predicts taken after a single not-taken update.
- R5: On a hit of a non-return entry whose counter predicts taken, predicted_target is the destination stored by the last taken update that wrote that entry.
- R6: A resolved call pushes its address plus 4. A resolved return pops. A return entry that hits predicts taken to the current top of the stack, in last-in first-out order.
- R7: Counters are shared by every address with the same index. Updates from one branch change the direction predicted for another branch at that index.
- R8: The stack holds 4 entries. A push when full overwrites the oldest entry, so the newest 4 remain.
- R9: A return entry that hits while the stack is empty gives no prediction (hit 0, predict_taken 0). A pop from an empty stack leaves it empty.
- R10: A flush empties the return stack as of the next cycle.
- R11: A lookup and an update in the same cycle see the state from before the update. The update is visible from the next cycle.
- R12: Whenever predict_taken is 0, predicted_target is fetch_pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the return stack |
| fetch_pc | input | 32 | Lookup address |
| upd_valid | input | 1 | Resolve port carries a branch this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved destination |
| upd_is_call | input | 1 | Resolved branch is a call |
| upd_is_ret | input | 1 | Resolved branch is a return |
| predict_taken | output | 1 | Predicted direction |
| predicted_target | output | 32 | Predicted next fetch address |
| hit | output | 1 | A tagged buffer entry supplies this prediction |

## Verification
The hardest conditions to reach are the return stack after it has wrapped, and a counter being moved by a different branch that shares its index. The bench reaches the wrap with five back-to-back resolved calls after one earlier push, then drains the stack with returns, checking each top and the empty state at the end. For aliasing, two addresses 256 bytes apart take turns updating one index. Each step checks both the replacement in the tagged buffer and the shift in the shared counter's direction.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;
  typedef logic [1:0] sat2_t;

  localparam sat2_t CTR_RESET = 2'd1;

  // saturating two-bit step toward the observed outcome
  function automatic sat2_t ctr_step(input sat2_t c, input logic tk);
    if (tk) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input sat2_t c);
    return c >= 2'd2;
  endfunction
endpackage

// File: rtl/bp_dir_table.sv
`timescale 1ns/1ps
module bp_dir_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import bp_pkg::*;
  localparam int ENTRIES = 1 << IDX_W;

  sat2_t ctr [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr[i] <= CTR_RESET;
    end else if (wr_en) begin
      ctr[wr_idx] <= ctr_step(ctr[wr_idx], wr_taken);
    end
  end

  assign rd_taken = ctr_says_taken(ctr[rd_idx]);

  // R3: saturation at the top
  a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && ctr[wr_idx] == 2'd3 |=> ctr[$past(wr_idx)] == 2'd3);
  // R3: saturation at the bottom
  a_r3_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && ctr[wr_idx] == 2'd0 |=> ctr[$past(wr_idx)] == 2'd0);
  // R4: one miss from strong taken keeps a taken prediction
  a_r4_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && ctr[wr_idx] == 2'd3 |=> ctr[$past(wr_idx)] == 2'd2);
endmodule

// File: rtl/bp_target_buf.sv
`timescale 1ns/1ps
module bp_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_target,
  output logic             rd_is_ret,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target,
  input  logic             wr_is_ret
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [ENTRIES-1:0] ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      valid <= '0;
    else if (wr_en)  valid[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_target;
      ret_q[wr_idx] <= wr_is_ret;
    end
  end

  assign rd_hit    = valid[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_target = tgt_q[rd_idx];
  assign rd_is_ret = ret_q[rd_idx];

  // R2: a written entry holds the writer's tag next cycle
  a_r2_entry_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag));
  // R5: the stored destination is the written one
  a_r5_target_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tgt_q[$past(wr_idx)] == $past(wr_target));
endmodule

// File: rtl/bp_ret_stack.sv
`timescale 1ns/1ps
module bp_ret_stack #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            push,
  input  logic [PC_W-1:0] push_val,
  input  logic            pop,
  output logic [PC_W-1:0] top,
  output logic            nonempty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [PTR_W-1:0] wrap_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  logic do_push, do_pop;
  assign do_push = push && !flush;
  assign do_pop  = pop && !push && !flush && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      count  <= '0;
    end else if (do_push) begin
      wr_ptr <= wrap_inc(wr_ptr);
      if (count != FULL) count <= count + 1'b1;
    end else if (do_pop) begin
      wr_ptr <= wrap_dec(wr_ptr);
      count  <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_val;
  end

  assign top      = mem[wrap_dec(wr_ptr)];
  assign nonempty = (count != '0);

  // R8: a push on a full stack keeps it full
  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush && count == FULL |=> count == FULL);
  // R8: occupancy never exceeds the depth
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n) count <= FULL);
  // R9: popping an empty stack leaves it empty
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && !flush && count == '0 |=> count == '0);
  // R10: flush empties the stack
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !nonempty);
  // R6: the pushed address becomes the top
  a_r6_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush |=> nonempty && top == $past(push_val));
endmodule

// File: rtl/branch_predictor.sv
`timescale 1ns/1ps
module branch_predictor #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 6,
  parameter int RAS_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_is_call,
  input  logic            upd_is_ret,
  output logic            predict_taken,
  output logic [PC_W-1:0] predicted_target,
  output logic            hit
);
  localparam int TAG_W = PC_W - IDX_W - 2;

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  logic [IDX_W-1:0] look_idx, upd_idx;
  logic [TAG_W-1:0] look_tag, upd_tag;
  assign look_idx = fetch_pc[IDX_W+1:2];
  assign look_tag = fetch_pc[PC_W-1:IDX_W+2];
  assign upd_idx  = upd_pc[IDX_W+1:2];
  assign upd_tag  = upd_pc[PC_W-1:IDX_W+2];

  // internal events, named for the checks below
  logic            dir_taken, buf_hit, buf_is_ret, stack_ok;
  logic [PC_W-1:0] buf_target, stack_top, fall_through;
  logic            ev_counter_upd, ev_buf_write, ev_push, ev_pop;

  assign ev_counter_upd = upd_valid;
  assign ev_buf_write   = upd_valid && upd_taken;
  assign ev_push        = upd_valid && upd_is_call;
  assign ev_pop         = upd_valid && upd_is_ret && !upd_is_call;

  bp_dir_table #(.IDX_W(IDX_W)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_taken(dir_taken),
    .wr_en(ev_counter_upd), .wr_idx(upd_idx), .wr_taken(upd_taken)
  );

  bp_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_tag(look_tag),
    .rd_hit(buf_hit), .rd_target(buf_target), .rd_is_ret(buf_is_ret),
    .wr_en(ev_buf_write), .wr_idx(upd_idx), .wr_tag(upd_tag),
    .wr_target(upd_target), .wr_is_ret(upd_is_ret)
  );

  bp_ret_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(ev_push), .push_val(seq_next(upd_pc)),
    .pop(ev_pop), .top(stack_top), .nonempty(stack_ok)
  );

  assign fall_through     = seq_next(fetch_pc);
  assign hit              = buf_hit && (!buf_is_ret || stack_ok);
  assign predict_taken    = hit && (buf_is_ret || dir_taken);
  assign predicted_target = !predict_taken ? fall_through :
                            (buf_is_ret ? stack_top : buf_target);

  // R12: a not-taken prediction falls through
  a_r12_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    !predict_taken |-> predicted_target == fetch_pc + 32'd4);
  // R2: direction is only claimed for a tagged entry
  a_r2_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    predict_taken |-> hit);
  // R9: an empty stack gives no return prediction
  a_r9_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    buf_hit && buf_is_ret && !stack_ok |-> !hit && !predict_taken);
  // R6: a usable return entry always redirects to the stack top
  a_r6_ret_to_top: assert property (@(posedge clk) disable iff (!rst_n)
    buf_hit && buf_is_ret && stack_ok |-> predict_taken && predicted_target == stack_top);
endmodule

// File: tb/tb_branch_predictor.sv
`timescale 1ns/1ps
module tb_branch_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic        upd_is_call = 1'b0;
  logic        upd_is_ret = 1'b0;
  logic        predict_taken, hit;
  logic [31:0] predicted_target;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  branch_predictor dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_pc(fetch_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_is_call(upd_is_call), .upd_is_ret(upd_is_ret),
    .predict_taken(predict_taken), .predicted_target(predicted_target), .hit(hit)
  );

  typedef struct packed {
    logic        u;
    logic [31:0] pc;
    logic        tk;
    logic [31:0] tgt;
    logic        call;
    logic        ret;
    logic [31:0] look;
    logic        eh;
    logic        etk;
    logic [31:0] etgt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 32'h100,  1'b0, 1'b0, 32'h104},
    '{1'b1, 32'h100,  1'b1, 32'h400,  1'b0, 1'b0, 32'h100,  1'b1, 1'b1, 32'h400},
    '{1'b1, 32'h100,  1'b1, 32'h400,  1'b0, 1'b0, 32'h100,  1'b1, 1'b1, 32'h400},
    '{1'b1, 32'h100,  1'b0, 32'h0,    1'b0, 1'b0, 32'h100,  1'b1, 1'b1, 32'h400},
    '{1'b1, 32'h100,  1'b0, 32'h0,    1'b0, 1'b0, 32'h100,  1'b1, 1'b0, 32'h104},
    '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 32'h200,  1'b0, 1'b0, 32'h204},
    '{1'b1, 32'h200,  1'b1, 32'h800,  1'b0, 1'b0, 32'h100,  1'b0, 1'b0, 32'h104},
    '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 32'h200,  1'b1, 1'b1, 32'h800},
    '{1'b1, 32'h100,  1'b1, 32'h400,  1'b0, 1'b0, 32'h100,  1'b1, 1'b1, 32'h400},
    '{1'b1, 32'h200,  1'b0, 32'h0,    1'b0, 1'b0, 32'h100,  1'b1, 1'b1, 32'h400},
    '{1'b1, 32'h200,  1'b0, 32'h0,    1'b0, 1'b0, 32'h100,  1'b1, 1'b0, 32'h104},
    '{1'b1, 32'h1010, 1'b1, 32'h3000, 1'b1, 1'b0, 32'h3040, 1'b0, 1'b0, 32'h3044},
    '{1'b1, 32'h3040, 1'b1, 32'h1014, 1'b0, 1'b1, 32'h3040, 1'b0, 1'b0, 32'h3044},
    '{1'b1, 32'h1020, 1'b1, 32'h3000, 1'b1, 1'b0, 32'h3040, 1'b1, 1'b1, 32'h1024}
  };
  localparam string VTAG [NV] = '{"R1", "R3", "R5", "R4", "R3", "R2", "R2",
                                  "R5", "R7", "R7", "R7", "R12", "R9", "R6"};

  task automatic check(input string req, input logic eh, input logic etk,
                       input logic [31:0] etgt);
    checks++;
    if (hit !== eh || predict_taken !== etk || predicted_target !== etgt) begin
      errors++;
      $display("FAIL %s pc=%h actual hit=%b tk=%b tgt=%h expected hit=%b tk=%b tgt=%h",
               req, fetch_pc, hit, predict_taken, predicted_target, eh, etk, etgt);
    end
  endtask

  // drive one resolve (optional) plus a lookup; check one edge later
  task automatic step(input vec_t v, input logic fl, input string req);
    @(negedge clk);
    upd_valid = v.u; upd_pc = v.pc; upd_taken = v.tk; upd_target = v.tgt;
    upd_is_call = v.call; upd_is_ret = v.ret; flush = fl; fetch_pc = v.look;
    @(posedge clk);
    #1;
    upd_valid = 1'b0; flush = 1'b0;
    check(req, v.eh, v.etk, v.etgt);
  endtask

  function automatic vec_t mk(input logic u, input logic [31:0] pc, input logic tk,
                              input logic [31:0] tgt, input logic call, input logic ret,
                              input logic [31:0] look, input logic eh, input logic etk,
                              input logic [31:0] etgt);
    vec_t v;
    v = '{u, pc, tk, tgt, call, ret, look, eh, etk, etgt};
    return v;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < NV; i++) step(VECS[i], 1'b0, VTAG[i]);

    // R6: LIFO order, stack holds 0x1024
    step(mk(1, 32'h1030, 1, 32'h3000, 1, 0, 32'h3040, 1, 1, 32'h1034), 1'b0, "R6");
    step(mk(1, 32'h3040, 1, 32'h1034, 0, 1, 32'h3040, 1, 1, 32'h1024), 1'b0, "R6");

    // R8: five calls onto one entry: oldest two are overwritten
    step(mk(1, 32'h2000, 1, 32'h3000, 1, 0, 32'h3040, 1, 1, 32'h2004), 1'b0, "R8");
    step(mk(1, 32'h2008, 1, 32'h3000, 1, 0, 32'h3040, 1, 1, 32'h200C), 1'b0, "R8");
    step(mk(1, 32'h2018, 1, 32'h3000, 1, 0, 32'h3040, 1, 1, 32'h201C), 1'b0, "R8");
    step(mk(1, 32'h2020, 1, 32'h3000, 1, 0, 32'h3040, 1, 1, 32'h2024), 1'b0, "R8");
    step(mk(1, 32'h2028, 1, 32'h3000, 1, 0, 32'h3040, 1, 1, 32'h202C), 1'b0, "R8");
    step(mk(1, 32'h3040, 1, 32'h202C, 0, 1, 32'h3040, 1, 1, 32'h2024), 1'b0, "R8");
    step(mk(1, 32'h3040, 1, 32'h2024, 0, 1, 32'h3040, 1, 1, 32'h201C), 1'b0, "R8");
    step(mk(1, 32'h3040, 1, 32'h201C, 0, 1, 32'h3040, 1, 1, 32'h200C), 1'b0, "R8");
    // R9: drained after the surviving four
    step(mk(1, 32'h3040, 1, 32'h200C, 0, 1, 32'h3040, 0, 0, 32'h3044), 1'b0, "R9");
    step(mk(1, 32'h3040, 1, 32'h0,    0, 1, 32'h3040, 0, 0, 32'h3044), 1'b0, "R9");
    step(mk(1, 32'h1030, 1, 32'h3000, 1, 0, 32'h3040, 1, 1, 32'h1034), 1'b0, "R9");

    // R10: flush empties the stack
    step(mk(1, 32'h1030, 1, 32'h3000, 1, 0, 32'h3040, 1, 1, 32'h1034), 1'b0, "R10");
    step(mk(0, 32'h0, 0, 32'h0, 0, 0, 32'h3040, 0, 0, 32'h3044), 1'b1, "R10");

    // R11: lookup and update in one cycle see the old state
    @(negedge clk);
    fetch_pc = 32'h504;
    upd_valid = 1'b1; upd_pc = 32'h504; upd_taken = 1'b1; upd_target = 32'h900;
    upd_is_call = 1'b0; upd_is_ret = 1'b0;
    #1 check("R11", 1'b0, 1'b0, 32'h508);
    @(posedge clk);
    #1 upd_valid = 1'b0;
    check("R11", 1'b1, 1'b1, 32'h900);

    // R1: reset clears learned state
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1", 1'b0, 1'b0, 32'h508);
    fetch_pc = 32'h100;
    #0 check("R1", 1'b0, 1'b0, 32'h104);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule